// File: doc/BRIEF.md
# Cache Port Flow Controller

This block is the flow-control front end of one cache port. Toward the peer it decides, in the same cycle, whether an incoming packet is taken or refused. While the cache has the port blocked, requests are refused and the block remembers that it owes the peer a retry. That retry is paid back as a single pulse when the port is unblocked. On the CPU side, a cacheable invalidate or upgrade that carries no read and no write is taken at once, is flagged as satisfied, and never produces a reply.

Toward the peer the block also owns one send slot per cycle. Responses from the cache either go straight out or wait in an ordered drain queue. Queued responses always leave before any new outbound request. Outbound requests are miss requests on a memory-side port and coherence requests on a CPU-side port. If the peer refuses a send, the block waits for the peer's retry. After a successful send with work still left, it tries again on the next cycle without further prompting. Cache lookup, miss tracking and storage stay outside the block and are reached through plain request and grant signals.

Top module: `cache_port_flow`

## Requirements
- R1: When a request (`in_req`=1) arrives while the port is blocked and it is not the CPU-side shortcut of R4, `in_accept` and `fwd_valid` are 0 and a must-retry flag is recorded. Any other valid packet is accepted. Every accepted packet that is not the R4 shortcut is forwarded on `fwd_valid`.
- R2: `set_block` takes effect only while unblocked, and it clears must-retry. `set_block` while already blocked has no effect. `clr_block` has no effect while unblocked.
- R3: `clr_block` while blocked raises `retry_out` for exactly one cycle, in the following cycle, if must-retry was set or a request is refused in that same cycle. Otherwise no pulse is raised. Must-retry is cleared either way.
- R4: On a CPU-side port (`IS_CPU_SIDE`=1), a valid packet with `in_cacheable`=1, `in_inval`=1, `in_read`=0 and `in_write`=0 is accepted even while blocked. It raises `in_satisfied` and is not forwarded. A memory-side port never raises `in_satisfied`.
- R5: An offered response is taken when `rsp_ready` is 1. It is sent in the same cycle if the queue is empty and the port is not waiting for a retry. Otherwise it is appended to the tail of the queue. A refused direct send enters the queue and sets waiting.
- R6: A send attempt happens on `send_kick`, on a pending self-retry (R7), or on `peer_retry` while waiting. The attempt sends the queue head first. Only with an empty queue does it send the outbound request and pulse `obr_take` on success. `snd_kind` codes are 0 none, 1 response, 2 miss request (memory side), 3 coherence request (CPU side).
- R7: After a successful queue send, a new attempt is made in the next cycle without a kick if entries or an outbound request remain. The same holds after a successful outbound request.
- R8: `snd_status` is 1 (nacked) for a response offered with `rsp_nack`=1 and 0 (success) otherwise.
- R9: A peer retry that finds the queue empty and no outbound request pending clears waiting and sends nothing.
- R10: `drain_chk` pulses in each cycle in which the queue goes from non-empty to empty.
- R11: With `DEPTH` entries queued, `rsp_ready` is 0 and no response is taken.
- R12: Synchronous active-high reset clears blocked, must-retry, waiting and the pending retry pulse, and empties the queue.
- R13: While waiting for a retry and `peer_retry` is 0, nothing is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming packet from peer |
| in_req | input | 1 | Packet is a request |
| in_cacheable | input | 1 | Packet targets cacheable space |
| in_inval | input | 1 | Packet invalidates |
| in_read | input | 1 | Packet reads |
| in_write | input | 1 | Packet writes |
| in_accept | output | 1 | Packet taken this cycle |
| fwd_valid | output | 1 | Packet handed to the cache |
| in_satisfied | output | 1 | Shortcut packet finished without reply |
| set_block | input | 1 | Cache asks to block the port |
| clr_block | input | 1 | Cache asks to unblock the port |
| retry_out | output | 1 | Retry indication to peer |
| rsp_valid | input | 1 | Cache offers a response |
| rsp_nack | input | 1 | Offered response is nacked |
| rsp_data | input | W | Offered response payload |
| rsp_ready | output | 1 | Response can be taken |
| obr_pending | input | 1 | Cache has an outbound request |
| obr_data | input | W | Outbound request payload |
| obr_take | output | 1 | Outbound request was sent |
| send_kick | input | 1 | Send opportunity from the cache |
| snd_valid | output | 1 | Send to peer this cycle |
| snd_kind | output | 2 | Kind of send (R6 codes) |
| snd_status | output | 1 | Result code of a response |
| snd_data | output | W | Send payload |
| snd_ok | input | 1 | Peer took the send |
| peer_retry | input | 1 | Peer invites a resend |
| drain_chk | output | 1 | Queue has just become empty |

## Verification
A new response can meet a queue drain, or an outbound request attempt, in the same cycle. So can an unblock meet a refused request. The bench provokes these by driving `rsp_valid`, `send_kick` and `peer_retry` together, and by pairing `clr_block` with a request. It does so in directed steps and over thousands of random cycles. A behavioural model built on a queue predicts every output in every cycle, and each output is compared. That covers which packet takes the slot, whether an order is broken and whether the owed retry is lost. A memory-side instance runs on the same stimulus to check the kind codes and the absence of the shortcut.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
    typedef enum logic [1:0] {
        SK_NONE = 2'd0,
        SK_RSP  = 2'd1,
        SK_MISS = 2'd2,
        SK_COH  = 2'd3
    } send_kind_e;
endpackage

// File: rtl/cpf_rsp_fifo.sv
module cpf_rsp_fifo #(
    parameter int DEPTH = 4,
    parameter int EW    = 17
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [EW-1:0]                  push_word,
    input  logic                           pop,
    output logic [EW-1:0]                  head_word,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t          st_d, st_q;
    logic [EW-1:0] mem_d [DEPTH];
    logic [EW-1:0] mem_q [DEPTH];

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (push) begin
            mem_d[st_q.wr] = push_word;
            st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
        mem_q <= mem_d;
    end

    assign head_word = mem_q[st_q.rd];
    assign count     = st_q.cnt;

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        !(push && !pop && st_q.cnt == FULL));
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> st_q.cnt != '0);
    p_count_bound_r11: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= FULL);
endmodule

// File: rtl/cpf_block_ctl.sv
module cpf_block_ctl #(
    parameter bit IS_CPU_SIDE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_req,
    input  logic in_cacheable,
    input  logic in_inval,
    input  logic in_read,
    input  logic in_write,
    input  logic set_block,
    input  logic clr_block,
    output logic in_accept,
    output logic fwd_valid,
    output logic in_satisfied,
    output logic retry_out
);
    typedef struct packed {
        logic blocked;
        logic must_retry;
        logic retry;
    } blk_t;

    blk_t blk_d, blk_q;
    logic shortcut;
    logic refused;

    generate
        if (IS_CPU_SIDE) begin : g_cpu
            assign shortcut = in_valid && in_cacheable && in_inval && !in_read && !in_write;
        end else begin : g_mem
            assign shortcut = 1'b0;
        end
    endgenerate

    always_comb begin
        refused      = in_valid && in_req && blk_q.blocked && !shortcut;
        in_accept    = in_valid && !refused;
        fwd_valid    = in_valid && !refused && !shortcut;
        in_satisfied = shortcut;

        blk_d       = blk_q;
        blk_d.retry = 1'b0;
        if (set_block && !blk_q.blocked) begin
            blk_d.blocked    = 1'b1;
            blk_d.must_retry = 1'b0;
        end else if (clr_block && blk_q.blocked) begin
            blk_d.blocked    = 1'b0;
            blk_d.must_retry = 1'b0;
            blk_d.retry      = blk_q.must_retry || refused;
        end else if (refused) begin
            blk_d.must_retry = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) blk_q <= '0;
        else     blk_q <= blk_d;
    end

    assign retry_out = blk_q.retry;

    p_refuse_logged_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_req && blk_q.blocked && !shortcut)
        |=> (blk_q.must_retry || !blk_q.blocked));
    p_retry_single_r3: assert property (@(posedge clk) disable iff (rst)
        retry_out |=> !retry_out);
    p_retry_unblocked_r3: assert property (@(posedge clk) disable iff (rst)
        retry_out |-> !blk_q.blocked && !blk_q.must_retry);
    p_shortcut_r4: assert property (@(posedge clk) disable iff (rst)
        in_satisfied |-> in_accept && !fwd_valid);
endmodule

// File: rtl/cpf_send_arb.sv
module cpf_send_arb
    import cpf_pkg::*;
#(
    parameter bit IS_CPU_SIDE = 1'b0,
    parameter int DEPTH       = 4,
    parameter int W           = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rsp_valid,
    input  logic                        rsp_nack,
    input  logic [W-1:0]                rsp_data,
    output logic                        rsp_ready,
    input  logic                        obr_pending,
    input  logic [W-1:0]                obr_data,
    output logic                        obr_take,
    input  logic                        send_kick,
    input  logic                        peer_retry,
    input  logic                        snd_ok,
    output logic                        snd_valid,
    output logic [1:0]                  snd_kind,
    output logic                        snd_status,
    output logic [W-1:0]                snd_data,
    output logic                        drain_chk,
    input  logic [$clog2(DEPTH+1)-1:0]  q_count,
    input  logic [W:0]                  q_head,
    output logic                        q_push,
    output logic [W:0]                  q_push_word,
    output logic                        q_pop
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam send_kind_e OBR_KIND = IS_CPU_SIDE ? SK_COH : SK_MISS;

    typedef struct packed {
        logic waiting;
        logic kick;
    } arb_t;

    arb_t             arb_d, arb_q;
    logic             q_empty;
    logic             rsp_take;
    logic             direct;
    logic             attempt;
    logic [CNT_W-1:0] cnt_after;
    send_kind_e       kind;

    always_comb begin
        q_empty     = (q_count == '0);
        rsp_ready   = (q_count != FULL);
        rsp_take    = rsp_valid && rsp_ready;
        direct      = rsp_take && q_empty && !arb_q.waiting;
        attempt     = arb_q.waiting ? peer_retry : (arb_q.kick || send_kick);

        arb_d       = arb_q;
        arb_d.kick  = 1'b0;
        snd_valid   = 1'b0;
        kind        = SK_NONE;
        snd_status  = 1'b0;
        snd_data    = '0;
        q_push      = 1'b0;
        q_push_word = {rsp_nack, rsp_data};
        q_pop       = 1'b0;
        obr_take    = 1'b0;

        if (direct) begin
            snd_valid  = 1'b1;
            kind       = SK_RSP;
            snd_status = rsp_nack;
            snd_data   = rsp_data;
            if (snd_ok) begin
                arb_d.kick = attempt;
            end else begin
                q_push        = 1'b1;
                arb_d.waiting = 1'b1;
            end
        end else begin
            q_push = rsp_take;
            if (attempt) begin
                if (!q_empty) begin
                    snd_valid  = 1'b1;
                    kind       = SK_RSP;
                    snd_status = q_head[W];
                    snd_data   = q_head[W-1:0];
                    if (snd_ok) begin
                        q_pop         = 1'b1;
                        arb_d.waiting = 1'b0;
                    end else begin
                        arb_d.waiting = 1'b1;
                    end
                end else if (obr_pending) begin
                    snd_valid = 1'b1;
                    kind      = OBR_KIND;
                    snd_data  = obr_data;
                    if (snd_ok) begin
                        obr_take      = 1'b1;
                        arb_d.waiting = 1'b0;
                        arb_d.kick    = 1'b1;
                    end else begin
                        arb_d.waiting = 1'b1;
                    end
                end else begin
                    arb_d.waiting = 1'b0;
                    arb_d.kick    = q_push;
                end
            end
        end

        cnt_after = q_count + CNT_W'(q_push) - CNT_W'(q_pop);
        if (q_pop) begin
            arb_d.kick = (cnt_after != '0) || obr_pending;
        end
        drain_chk = !q_empty && (cnt_after == '0);
        snd_kind  = kind;
    end

    always_ff @(posedge clk) begin
        if (rst) arb_q <= '0;
        else     arb_q <= arb_d;
    end

    p_queue_first_r6: assert property (@(posedge clk) disable iff (rst)
        (snd_valid && snd_kind != SK_RSP) |-> q_count == '0);
    p_quiet_wait_r13: assert property (@(posedge clk) disable iff (rst)
        (arb_q.waiting && !peer_retry) |-> !snd_valid);
    p_no_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (!arb_q.waiting && q_count != '0) |-> arb_q.kick);
    p_refused_waits_r5: assert property (@(posedge clk) disable iff (rst)
        (snd_valid && !snd_ok) |=> arb_q.waiting);
endmodule

// File: rtl/cache_port_flow.sv
module cache_port_flow #(
    parameter bit IS_CPU_SIDE = 1'b0,
    parameter int DEPTH       = 4,
    parameter int W           = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_req,
    input  logic         in_cacheable,
    input  logic         in_inval,
    input  logic         in_read,
    input  logic         in_write,
    output logic         in_accept,
    output logic         fwd_valid,
    output logic         in_satisfied,
    input  logic         set_block,
    input  logic         clr_block,
    output logic         retry_out,
    input  logic         rsp_valid,
    input  logic         rsp_nack,
    input  logic [W-1:0] rsp_data,
    output logic         rsp_ready,
    input  logic         obr_pending,
    input  logic [W-1:0] obr_data,
    output logic         obr_take,
    input  logic         send_kick,
    output logic         snd_valid,
    output logic [1:0]   snd_kind,
    output logic         snd_status,
    output logic [W-1:0] snd_data,
    input  logic         snd_ok,
    input  logic         peer_retry,
    output logic         drain_chk
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] q_count;
    logic [W:0]       q_head;
    logic [W:0]       q_push_word;
    logic             q_push;
    logic             q_pop;

    cpf_block_ctl #(.IS_CPU_SIDE(IS_CPU_SIDE)) u_blk (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_req(in_req), .in_cacheable(in_cacheable),
        .in_inval(in_inval), .in_read(in_read), .in_write(in_write),
        .set_block(set_block), .clr_block(clr_block),
        .in_accept(in_accept), .fwd_valid(fwd_valid),
        .in_satisfied(in_satisfied), .retry_out(retry_out)
    );

    cpf_rsp_fifo #(.DEPTH(DEPTH), .EW(W + 1)) u_fifo (
        .clk(clk), .rst(rst),
        .push(q_push), .push_word(q_push_word), .pop(q_pop),
        .head_word(q_head), .count(q_count)
    );

    cpf_send_arb #(.IS_CPU_SIDE(IS_CPU_SIDE), .DEPTH(DEPTH), .W(W)) u_arb (
        .clk(clk), .rst(rst),
        .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_data(rsp_data),
        .rsp_ready(rsp_ready),
        .obr_pending(obr_pending), .obr_data(obr_data), .obr_take(obr_take),
        .send_kick(send_kick), .peer_retry(peer_retry), .snd_ok(snd_ok),
        .snd_valid(snd_valid), .snd_kind(snd_kind), .snd_status(snd_status),
        .snd_data(snd_data), .drain_chk(drain_chk),
        .q_count(q_count), .q_head(q_head),
        .q_push(q_push), .q_push_word(q_push_word), .q_pop(q_pop)
    );
endmodule

// File: tb/tb_cache_port_flow.sv
module tb_cache_port_flow;
    localparam int DEPTH = 4;
    localparam int W     = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic in_valid, in_req, in_cacheable, in_inval, in_read, in_write;
    logic set_block, clr_block, rsp_valid, rsp_nack, obr_pending, send_kick;
    logic snd_ok, peer_retry;
    logic [W-1:0] rsp_data, obr_data;

    logic c_acc, c_fwd, c_sat, c_retry, c_rdy, c_take, c_sv, c_st, c_chk;
    logic [1:0] c_kind;
    logic [W-1:0] c_data;
    logic m_acc, m_fwd, m_sat, m_retry, m_rdy, m_take, m_sv, m_st, m_chk;
    logic [1:0] m_kind;
    logic [W-1:0] m_data;

    cache_port_flow #(.IS_CPU_SIDE(1'b1), .DEPTH(DEPTH), .W(W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_req(in_req),
        .in_cacheable(in_cacheable), .in_inval(in_inval), .in_read(in_read),
        .in_write(in_write), .in_accept(c_acc), .fwd_valid(c_fwd),
        .in_satisfied(c_sat), .set_block(set_block), .clr_block(clr_block),
        .retry_out(c_retry), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
        .rsp_data(rsp_data), .rsp_ready(c_rdy), .obr_pending(obr_pending),
        .obr_data(obr_data), .obr_take(c_take), .send_kick(send_kick),
        .snd_valid(c_sv), .snd_kind(c_kind), .snd_status(c_st),
        .snd_data(c_data), .snd_ok(snd_ok), .peer_retry(peer_retry),
        .drain_chk(c_chk)
    );

    cache_port_flow #(.IS_CPU_SIDE(1'b0), .DEPTH(DEPTH), .W(W)) dut_m (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_req(in_req),
        .in_cacheable(in_cacheable), .in_inval(in_inval), .in_read(in_read),
        .in_write(in_write), .in_accept(m_acc), .fwd_valid(m_fwd),
        .in_satisfied(m_sat), .set_block(set_block), .clr_block(clr_block),
        .retry_out(m_retry), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
        .rsp_data(rsp_data), .rsp_ready(m_rdy), .obr_pending(obr_pending),
        .obr_data(obr_data), .obr_take(m_take), .send_kick(send_kick),
        .snd_valid(m_sv), .snd_kind(m_kind), .snd_status(m_st),
        .snd_data(m_data), .snd_ok(snd_ok), .peer_retry(peer_retry),
        .drain_chk(m_chk)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit md_blk, md_mret, md_wait, md_kick, md_retry;
    int md_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic quiet();
        {in_valid, in_req, in_cacheable, in_inval, in_read, in_write} = '0;
        {set_block, clr_block, rsp_valid, rsp_nack, obr_pending, send_kick} = '0;
        {snd_ok, peer_retry} = '0;
        rsp_data = '0;
        obr_data = '0;
    endtask

    task automatic model_clear();
        md_blk = 0; md_mret = 0; md_wait = 0; md_kick = 0; md_retry = 0;
        md_q.delete();
    endtask

    task automatic tick();
        bit sc, refused, take, direct, att;
        bit e_acc, e_fwd, e_sv, e_st, e_take, e_chk, nw, nk;
        int e_kind, e_data;
        int nq[$];
        #2;
        sc      = in_valid && in_cacheable && in_inval && !in_read && !in_write;
        refused = in_valid && in_req && md_blk && !sc;
        e_acc   = in_valid && !refused;
        e_fwd   = in_valid && !refused && !sc;

        nq = md_q;
        take   = rsp_valid && (md_q.size() < DEPTH);
        direct = take && (md_q.size() == 0) && !md_wait;
        att    = md_wait ? peer_retry : (md_kick || send_kick);
        e_sv = 0; e_kind = 0; e_st = 0; e_data = 0; e_take = 0;
        nw = md_wait; nk = 0;
        if (direct) begin
            e_sv = 1; e_kind = 1; e_st = rsp_nack; e_data = rsp_data;
            if (snd_ok) nk = att;
            else begin nq.push_back({rsp_nack, rsp_data}); nw = 1; end
        end else begin
            if (take) nq.push_back({rsp_nack, rsp_data});
            if (att) begin
                if (md_q.size() > 0) begin
                    e_sv = 1; e_kind = 1;
                    e_st = md_q[0][W]; e_data = md_q[0] & 32'hFFFF;
                    if (snd_ok) begin
                        void'(nq.pop_front());
                        nw = 0;
                        nk = (nq.size() > 0) || obr_pending;
                    end else nw = 1;
                end else if (obr_pending) begin
                    e_sv = 1; e_kind = 3; e_data = obr_data;
                    if (snd_ok) begin e_take = 1; nw = 0; nk = 1; end
                    else nw = 1;
                end else begin
                    nw = 0; nk = take;
                end
            end
        end
        e_chk = (md_q.size() != 0) && (nq.size() == 0);

        // CPU-side instance
        chk(c_acc == e_acc, "R1 accept", c_acc, e_acc);
        chk(c_fwd == e_fwd, "R1 forward", c_fwd, e_fwd);
        chk(c_sat == sc, "R4 satisfied", c_sat, sc);
        chk(c_retry == md_retry, "R3 retry", c_retry, md_retry);
        chk(c_rdy == (md_q.size() < DEPTH), "R11 ready", c_rdy, md_q.size() < DEPTH);
        chk(c_sv == e_sv, "R13 send valid", c_sv, e_sv);
        chk(c_kind == e_kind, "R6 kind", c_kind, e_kind);
        chk(c_take == e_take, "R6 take", c_take, e_take);
        chk(c_chk == e_chk, "R10 drain check", c_chk, e_chk);
        if (e_sv) begin
            chk(c_st == e_st, "R8 status", c_st, e_st);
            chk(c_data == W'(e_data), "R5 data", c_data, e_data);
        end
        // memory-side instance: no shortcut, request kind 2
        chk(m_acc == e_acc && m_fwd == (in_valid && !refused) && !m_sat,
            "R4 mem-side input", {m_acc, m_fwd, m_sat}, {e_acc, in_valid && !refused, 1'b0});
        chk(m_retry == md_retry && m_rdy == c_rdy, "R3 mem-side retry", m_retry, md_retry);
        chk(m_sv == e_sv && m_take == e_take && m_chk == e_chk, "R6 mem-side send",
            {m_sv, m_take, m_chk}, {e_sv, e_take, e_chk});
        chk(m_kind == ((e_kind == 3) ? 2 : e_kind), "R6 mem-side kind", m_kind,
            (e_kind == 3) ? 2 : e_kind);

        @(posedge clk);
        if (rst) model_clear();
        else begin
            md_retry = 0;
            if (set_block && !md_blk) begin md_blk = 1; md_mret = 0; end
            else if (clr_block && md_blk) begin
                md_blk = 0; md_retry = md_mret || refused; md_mret = 0;
            end else if (refused) md_mret = 1;
            md_q = nq; md_wait = nw; md_kick = nk;
        end
        @(negedge clk);
    endtask

    task automatic peek_retry(input bit exp, input string tag);
        #1 chk(c_retry == exp, tag, c_retry, exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(7));
        quiet();
        model_clear();
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        // R12: reset state
        #1 chk(c_retry == 0 && c_sv == 0 && c_rdy == 1, "R12 reset outputs",
               {c_retry, c_sv, c_rdy}, 3'b001);
        tick();

        // R1/R3: refuse while blocked, one retry after unblock
        set_block = 1; tick(); quiet();
        in_valid = 1; in_req = 1; in_read = 1;
        #1 chk(c_acc == 0, "R1 refused while blocked", c_acc, 0);
        tick(); quiet();
        clr_block = 1; tick(); quiet();
        peek_retry(1, "R3 retry pulse"); tick();
        peek_retry(0, "R3 single pulse"); tick();

        // R2: re-blocking clears must-retry
        set_block = 1; tick(); quiet();
        in_valid = 1; in_req = 1; tick(); quiet();
        clr_block = 1; tick(); quiet(); tick();
        set_block = 1; tick(); quiet();
        clr_block = 1; tick(); quiet();
        peek_retry(0, "R2 no retry after fresh block"); tick();
        // R2: set while blocked ignored, must-retry kept
        set_block = 1; tick(); quiet();
        in_valid = 1; in_req = 1; tick(); quiet();
        set_block = 1; tick(); quiet();
        clr_block = 1; tick(); quiet();
        peek_retry(1, "R2 second set ignored"); tick();

        // R3: refusal in the unblock cycle
        set_block = 1; tick(); quiet();
        clr_block = 1; in_valid = 1; in_req = 1; tick(); quiet();
        peek_retry(1, "R3 same-cycle refusal"); tick();

        // R4: shortcut packet
        in_valid = 1; in_req = 1; in_cacheable = 1; in_inval = 1;
        #1 chk(c_sat == 1 && c_fwd == 0, "R4 shortcut", {c_sat, c_fwd}, 2'b10);
        tick(); quiet();

        // R5: direct response, then refused and queued
        rsp_valid = 1; rsp_data = 16'h1111; snd_ok = 1;
        #1 chk(c_sv == 1 && c_data == 16'h1111, "R5 direct send", c_data, 16'h1111);
        tick(); quiet();
        rsp_valid = 1; rsp_nack = 1; rsp_data = 16'h2222; tick(); quiet();
        for (int i = 0; i < 3; i++) begin
            rsp_valid = 1; rsp_data = W'(16'h3000 + i); tick(); quiet();
        end
        rsp_valid = 1; rsp_data = 16'hDEAD;
        #1 chk(c_rdy == 0, "R11 full queue", c_rdy, 0);
        tick(); quiet();
        obr_pending = 1; obr_data = 16'h0B0B; send_kick = 1;
        #1 chk(c_sv == 0, "R13 silent while waiting", c_sv, 1'b0);
        tick(); quiet();
        obr_pending = 1; obr_data = 16'h0B0B; peer_retry = 1; snd_ok = 1;
        #1 chk(c_st == 1 && c_data == 16'h2222, "R8 nacked head first", c_st, 1);
        tick(); quiet();
        obr_pending = 1; obr_data = 16'h0B0B; snd_ok = 1;
        #1 chk(c_sv == 1 && c_kind == 1, "R7 self retry next cycle", c_sv, 1);
        for (int i = 0; i < 4; i++) begin
            tick(); obr_pending = 1; obr_data = 16'h0B0B; snd_ok = 1;
        end
        tick(); quiet(); tick();

        // R9: retry with nothing pending clears waiting
        obr_pending = 1; obr_data = 16'h0C0C; send_kick = 1; tick(); quiet();
        peer_retry = 1;
        #1 chk(c_sv == 0, "R9 empty retry sends nothing", c_sv, 0);
        tick(); quiet();
        obr_pending = 1; obr_data = 16'h0C0C; send_kick = 1; snd_ok = 1;
        #1 chk(c_take == 1, "R9 waiting cleared", c_take, 1);
        tick(); quiet(); tick();

        // random mix: overlapping responses, drains, blocks and retries
        for (int n = 0; n < 4000; n++) begin
            in_valid     = ($urandom_range(0, 2) == 0);
            in_req       = $urandom_range(0, 1);
            in_cacheable = $urandom_range(0, 1);
            in_inval     = md_blk ? 1'b0 : 1'($urandom_range(0, 1));
            in_read      = ($urandom_range(0, 3) == 0);
            in_write     = ($urandom_range(0, 3) == 0);
            set_block    = ($urandom_range(0, 7) == 0);
            clr_block    = ($urandom_range(0, 5) == 0);
            rsp_valid    = ($urandom_range(0, 2) == 0);
            rsp_nack     = $urandom_range(0, 1);
            rsp_data     = W'($urandom);
            obr_pending  = ($urandom_range(0, 2) == 0);
            obr_data     = W'($urandom);
            send_kick    = ($urandom_range(0, 3) == 0);
            snd_ok       = ($urandom_range(0, 3) != 0);
            peer_retry   = ($urandom_range(0, 2) == 0);
            tick();
        end
        quiet();
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule